// File: doc/BRIEF.md
# PC-Localized Structural Address Mapper

This block turns temporal correlation in a load miss stream into sequential locality. Training updates arrive as a load PC and a physical line address. The block keeps, for each PC, the last address that PC touched. It gives the new address the structural index right after that predecessor's index, so each PC's stream takes up consecutive slots in an invented structural address space. Structural indices are handed out in chunks of 16 from a global counter. A stream that cannot continue its current chunk opens a new one.

Two direct-mapped tagged tables hold the mapping in both directions: a forward table (physical to structural) and a reverse table (structural to physical). A trigger address is looked up in the forward table. The next structural indices after it are translated back through the reverse table, and each valid translation comes out as a prefetch target. Prediction is therefore a next-line walk in structural space.

Top module: `smap_top`

## Requirements
- R1: After reset `pf_valid` is all zero. It stays zero in every cycle that does not follow a captured trigger. A trigger before any training issues nothing.
- R2: A training update whose PC has no valid entry gets a fresh chunk base. This includes a valid entry whose tag is different, because the PC table index is `pc[3:0]` and the tag is the remaining bits. The base is 16 times a global chunk counter that starts at 0 and increments by one on each fresh allocation.
- R3: When the PC's last address still has a forward mapping at structural index S, and S[3:0] is not 15, the new address gets index S+1 and the chunk counter does not change.
- R4: When that predecessor index S has S[3:0] equal to 15, the new address gets a fresh chunk base rather than S+1.
- R5: When the PC's last address has no forward mapping (its entry was overwritten by another address), the new address gets a fresh chunk base.
- R6: Each training update writes three entries: the forward entry for the new address, the reverse entry for the assigned index, and the PC's last address, which becomes the new address.
- R7: A trigger sampled at clock edge k drives results after edge k+1, for one cycle. `pf_valid[d]` and `pf_addr[32*d+31:32*d]` report the reverse translation of structural index S+d+1, where S is the trigger's index. A slot is valid only if that reverse entry is valid and its tag matches.
- R8: A trigger whose address has no forward mapping issues nothing in either slot.
- R9: A training update and a trigger presented in the same cycle behave as if the training finished first. The trigger sees the new mapping.
- R10: Both maps are direct-mapped with 64 entries. The forward index is address bits [5:0] and the reverse index is structural bits [5:0], each with a tag. A new write replaces the older mapping at that index, including the case where an address is retrained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trn_valid | input | 1 | Training update present |
| trn_pc | input | 32 | Load PC of the training update |
| trn_addr | input | 32 | Physical line address of the training update |
| trg_valid | input | 1 | Trigger lookup present |
| trg_addr | input | 32 | Physical line address of the trigger |
| pf_valid | output | 2 | Per-slot prefetch valid; bit d covers structural offset d+1 |
| pf_addr | output | 64 | Prefetch targets; slot d at bits [32*d+31:32*d] |

## Verification
On every cycle, the assertions check the following:
- the chunk counter steps only on fresh allocations and holds while a stream continues;
- a boundary or unmapped predecessor always yields a chunk-aligned index;
- each table write lands with its tag;
- the PC table records the new address;
- prefetch outputs appear only after a captured trigger and never after a forward miss.

Only the bench's scenarios can show the following:
- that the structural indices a stream receives are the right ones across interleaved PCs;
- that a PC alias or an evicted predecessor really opens a new chunk instead of chaining onto stale state;
- that retraining relocates an address;
- that a same-cycle training update is visible to the trigger.

// File: rtl/smap_pkg.sv
package smap_pkg;

  // Defaults shared by the mapper's modules.
  localparam int DEF_PA_W    = 32;
  localparam int DEF_PC_W    = 32;
  localparam int DEF_SA_W    = 16;
  localparam int DEF_CHUNK_W = 4;

  // Where a training update takes its structural index from.
  typedef enum logic [1:0] {
    SRC_CHAIN    = 2'd0,  // predecessor index plus one
    SRC_NEW_PC   = 2'd1,  // PC has no stream yet: fresh chunk
    SRC_NO_MAP   = 2'd2,  // predecessor lost its mapping: fresh chunk
    SRC_BOUNDARY = 2'd3   // predecessor ends a chunk: fresh chunk
  } sa_src_e;

endpackage

// File: rtl/smap_dm_table.sv
module smap_dm_table #(
  parameter int KEY_W = 32,
  parameter int VAL_W = 16,
  parameter int AW    = 6,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [KEY_W-1:0]          wr_key,
  input  logic [VAL_W-1:0]          wr_val,
  input  logic [NRD-1:0][KEY_W-1:0] rd_key,
  output logic [NRD-1:0]            rd_hit,
  output logic [NRD-1:0][VAL_W-1:0] rd_val
);

  localparam int DEPTH = 1 << AW;
  localparam int TAG_W = KEY_W - AW;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [VAL_W-1:0] val_q [DEPTH];

  logic [AW-1:0]    wr_idx;
  logic [TAG_W-1:0] wr_tag;

  assign wr_idx = wr_key[AW-1:0];
  assign wr_tag = wr_key[KEY_W-1:AW];

  // Read ports: combinational, one per requester.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0]    r_idx;
    logic [TAG_W-1:0] r_tag;
    assign r_idx     = rd_key[r][AW-1:0];
    assign r_tag     = rd_key[r][KEY_W-1:AW];
    assign rd_hit[r] = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
    assign rd_val[r] = val_q[r_idx];
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload carries no reset; the valid bit guards it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      val_q[wr_idx] <= wr_val;
    end
  end

  // R6 / R10: a write lands at its index with its tag and value, replacing whatever was there.
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))
              && (val_q[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/smap_train_unit.sv
module smap_train_unit
  import smap_pkg::*;
#(
  parameter int PC_W    = DEF_PC_W,
  parameter int PA_W    = DEF_PA_W,
  parameter int SA_W    = DEF_SA_W,
  parameter int PCT_AW  = 4,
  parameter int CHUNK_W = DEF_CHUNK_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trn_valid,
  input  logic [PC_W-1:0] trn_pc,
  input  logic [PA_W-1:0] trn_pa,
  // Forward lookup of the predecessor address
  output logic [PA_W-1:0] prev_pa,
  input  logic            prev_hit,
  input  logic [SA_W-1:0] prev_sa,
  // Map write request
  output logic            wr_en,
  output logic [PA_W-1:0] wr_pa,
  output logic [SA_W-1:0] wr_sa
);

  localparam int DEPTH = 1 << PCT_AW;
  localparam int TAG_W = PC_W - PCT_AW;
  localparam int CTR_W = SA_W - CHUNK_W;

  logic [DEPTH-1:0] pct_vld_q, pct_vld_d;
  logic [TAG_W-1:0] pct_tag_q [DEPTH];
  logic [PA_W-1:0]  pct_pa_q  [DEPTH];
  logic [CTR_W-1:0] alloc_q, alloc_d;

  logic [PCT_AW-1:0] idx;
  logic [TAG_W-1:0]  tag;
  logic              pc_hit;
  sa_src_e           src;
  logic [SA_W-1:0]   new_sa;

  assign idx     = trn_pc[PCT_AW-1:0];
  assign tag     = trn_pc[PC_W-1:PCT_AW];
  assign pc_hit  = pct_vld_q[idx] && (pct_tag_q[idx] == tag);
  assign prev_pa = pct_pa_q[idx];

  // Pick the source of the structural index.
  always_comb begin
    if (!pc_hit)                       src = SRC_NEW_PC;
    else if (!prev_hit)                src = SRC_NO_MAP;
    else if (&prev_sa[CHUNK_W-1:0])    src = SRC_BOUNDARY;
    else                               src = SRC_CHAIN;
  end

  always_comb begin
    if (src == SRC_CHAIN) new_sa = SA_W'(prev_sa + 1'b1);
    else                  new_sa = {alloc_q, {CHUNK_W{1'b0}}};
  end

  always_comb begin
    alloc_d = alloc_q;
    if (trn_valid && (src != SRC_CHAIN)) alloc_d = CTR_W'(alloc_q + 1'b1);
  end

  always_comb begin
    pct_vld_d = pct_vld_q;
    if (trn_valid) pct_vld_d[idx] = 1'b1;
  end

  assign wr_en = trn_valid;
  assign wr_pa = trn_pa;
  assign wr_sa = new_sa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q   <= '0;
      pct_vld_q <= '0;
    end else begin
      alloc_q   <= alloc_d;
      pct_vld_q <= pct_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (trn_valid) begin
      pct_tag_q[idx] <= tag;
      pct_pa_q[idx]  <= trn_pa;
    end
  end

  // R2: every fresh allocation advances the chunk counter by exactly one.
  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && (src != SRC_CHAIN)) |=> alloc_q == CTR_W'($past(alloc_q) + 1'b1));

  // R3: continuing a stream leaves the chunk counter untouched.
  p_chain_holds_ctr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && (src == SRC_CHAIN)) |=> $stable(alloc_q));

  // R4: a predecessor at the last slot of a chunk yields a chunk-aligned index.
  p_boundary_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && pc_hit && prev_hit && (&prev_sa[CHUNK_W-1:0]))
      |-> (wr_sa[CHUNK_W-1:0] == '0));

  // R5: an unmapped predecessor yields a chunk-aligned index.
  p_nomap_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && pc_hit && !prev_hit) |-> (wr_sa[CHUNK_W-1:0] == '0));

  // R6: the PC entry records the new address after the update.
  p_pct_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid |=> pct_vld_q[$past(idx)] && (pct_pa_q[$past(idx)] == $past(trn_pa))
                  && (pct_tag_q[$past(idx)] == $past(tag)));

endmodule

// File: rtl/smap_top.sv
module smap_top
  import smap_pkg::*;
#(
  parameter int PC_W    = DEF_PC_W,
  parameter int PA_W    = DEF_PA_W,
  parameter int SA_W    = DEF_SA_W,
  parameter int PCT_AW  = 4,
  parameter int MAP_AW  = 6,
  parameter int CHUNK_W = DEF_CHUNK_W,
  parameter int DEGREE  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trn_valid,
  input  logic [PC_W-1:0]        trn_pc,
  input  logic [PA_W-1:0]        trn_addr,
  input  logic                   trg_valid,
  input  logic [PA_W-1:0]        trg_addr,
  output logic [DEGREE-1:0]      pf_valid,
  output logic [DEGREE*PA_W-1:0] pf_addr
);

  localparam int FWD_RD  = 2;  // port 0: predecessor, port 1: trigger
  localparam int P_PREV  = 0;
  localparam int P_TRIG  = 1;

  // Trigger capture stage: a same-cycle training write lands first.
  logic            trg_q_vld;
  logic [PA_W-1:0] trg_q_pa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trg_q_vld <= 1'b0;
    else        trg_q_vld <= trg_valid;
  end

  always_ff @(posedge clk) begin
    if (trg_valid) trg_q_pa <= trg_addr;
  end

  // Training unit
  logic            wr_en;
  logic [PA_W-1:0] wr_pa;
  logic [SA_W-1:0] wr_sa;
  logic [PA_W-1:0] prev_pa;

  logic [FWD_RD-1:0]            fwd_hit;
  logic [FWD_RD-1:0][SA_W-1:0]  fwd_sa;
  logic [FWD_RD-1:0][PA_W-1:0]  fwd_key;

  smap_train_unit #(
    .PC_W(PC_W), .PA_W(PA_W), .SA_W(SA_W), .PCT_AW(PCT_AW), .CHUNK_W(CHUNK_W)
  ) u_train (
    .clk      (clk),
    .rst_n    (rst_n),
    .trn_valid(trn_valid),
    .trn_pc   (trn_pc),
    .trn_pa   (trn_addr),
    .prev_pa  (prev_pa),
    .prev_hit (fwd_hit[P_PREV]),
    .prev_sa  (fwd_sa[P_PREV]),
    .wr_en    (wr_en),
    .wr_pa    (wr_pa),
    .wr_sa    (wr_sa)
  );

  assign fwd_key[P_PREV] = prev_pa;
  assign fwd_key[P_TRIG] = trg_q_pa;

  // Forward map: physical -> structural
  smap_dm_table #(
    .KEY_W(PA_W), .VAL_W(SA_W), .AW(MAP_AW), .NRD(FWD_RD)
  ) u_fwd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_key(wr_pa),
    .wr_val(wr_sa),
    .rd_key(fwd_key),
    .rd_hit(fwd_hit),
    .rd_val(fwd_sa)
  );

  // Reverse map: structural -> physical, one read per prefetch slot
  logic [DEGREE-1:0]            rev_hit;
  logic [DEGREE-1:0][PA_W-1:0]  rev_pa;
  logic [DEGREE-1:0][SA_W-1:0]  rev_key;

  for (genvar d = 0; d < DEGREE; d++) begin : g_walk
    assign rev_key[d] = SA_W'(fwd_sa[P_TRIG] + SA_W'(d + 1));
  end

  smap_dm_table #(
    .KEY_W(SA_W), .VAL_W(PA_W), .AW(MAP_AW), .NRD(DEGREE)
  ) u_rev (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_key(wr_sa),
    .wr_val(wr_pa),
    .rd_key(rev_key),
    .rd_hit(rev_hit),
    .rd_val(rev_pa)
  );

  // Output stage
  logic [DEGREE-1:0]      pf_valid_d;
  logic [DEGREE*PA_W-1:0] pf_addr_d;

  always_comb begin
    for (int d = 0; d < DEGREE; d++) begin
      pf_valid_d[d]               = trg_q_vld && fwd_hit[P_TRIG] && rev_hit[d];
      pf_addr_d[d*PA_W +: PA_W]   = rev_pa[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_valid <= '0;
    else        pf_valid <= pf_valid_d;
  end

  always_ff @(posedge clk) begin
    if (trg_q_vld) pf_addr <= pf_addr_d;
  end

  // R7: targets appear only in the cycle after a captured trigger.
  p_pf_after_trigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pf_valid) |-> $past(trg_q_vld));

  // R1: a cycle with no captured trigger leaves the outputs quiet next cycle.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !trg_q_vld |=> (pf_valid == '0));

  // R8: a forward miss on the trigger issues nothing.
  p_miss_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_q_vld && !fwd_hit[P_TRIG]) |=> (pf_valid == '0));

  // R9: a training write to the trigger's own address is visible to its lookup.
  p_train_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && trg_valid && (trn_addr == trg_addr)) |=> fwd_hit[P_TRIG]);

endmodule

// File: tb/sim_smap_top.sv
module sim_smap_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trn_valid;
  logic [31:0] trn_pc;
  logic [31:0] trn_addr;
  logic        trg_valid;
  logic [31:0] trg_addr;
  logic [1:0]  pf_valid;
  logic [63:0] pf_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  smap_top u0 (
    .clk(clk), .rst_n(rst_n),
    .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_addr(trn_addr),
    .trg_valid(trg_valid), .trg_addr(trg_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  // Stream address generators (forward index = low 6 bits)
  function automatic logic [31:0] a_of(int k); return 32'h0000_1000 + k; endfunction // idx 0..5
  function automatic logic [31:0] b_of(int k); return 32'h0000_2008 + k; endfunction // idx 8..25
  localparam logic [31:0] C0 = 32'h0000_3020;   // idx 32
  localparam logic [31:0] D0 = 32'h0000_401E;   // idx 30
  localparam logic [31:0] D1 = 32'h0000_401F;   // idx 31
  localparam logic [31:0] E0 = 32'h0000_5028;   // idx 40
  localparam logic [31:0] F0 = 32'h0000_6028;   // idx 40, other tag
  localparam logic [31:0] E1 = 32'h0000_502A;   // idx 42
  localparam logic [31:0] E2 = 32'h0000_502B;   // idx 43
  localparam logic [31:0] G0 = 32'h0000_7030;   // idx 48
  localparam logic [31:0] G1 = 32'h0000_7031;   // idx 49

  localparam logic [31:0] PC_A = 32'h100;  // pc idx 0
  localparam logic [31:0] PC_B = 32'h101;
  localparam logic [31:0] PC_C = 32'h102;
  localparam logic [31:0] PC_D = 32'h110;  // pc idx 0, other tag
  localparam logic [31:0] PC_E = 32'h104;
  localparam logic [31:0] PC_F = 32'h105;
  localparam logic [31:0] PC_G = 32'h106;

  task automatic train(input logic [31:0] pc, input logic [31:0] pa);
    @(negedge clk);
    trn_valid = 1'b1; trn_pc = pc; trn_addr = pa;
    @(negedge clk);
    trn_valid = 1'b0;
  endtask

  task automatic expect_pf(input logic [1:0] ev, input logic [31:0] e0,
                           input logic [31:0] e1, input string req);
    tests++;
    if (pf_valid !== ev) begin
      fails++;
      $display("FAIL %s pf_valid actual=%b expected=%b", req, pf_valid, ev);
    end
    if (ev[0]) begin
      tests++;
      if (pf_addr[31:0] !== e0) begin
        fails++;
        $display("FAIL %s slot0 actual=%h expected=%h", req, pf_addr[31:0], e0);
      end
    end
    if (ev[1]) begin
      tests++;
      if (pf_addr[63:32] !== e1) begin
        fails++;
        $display("FAIL %s slot1 actual=%h expected=%h", req, pf_addr[63:32], e1);
      end
    end
  endtask

  // Trigger sampled at edge k; results checked after edge k+1.
  task automatic trig(input logic [31:0] pa, input logic [1:0] ev,
                      input logic [31:0] e0, input logic [31:0] e1, input string req);
    @(negedge clk);
    trg_valid = 1'b1; trg_addr = pa;
    @(negedge clk);
    trg_valid = 1'b0;
    @(negedge clk);
    expect_pf(ev, e0, e1, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trn_valid = 1'b0; trg_valid = 1'b0;
    trn_pc = '0; trn_addr = '0; trg_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: quiet after reset and on an untrained trigger
    @(negedge clk);
    expect_pf(2'b00, '0, '0, "R1 reset");
    trig(a_of(0), 2'b00, '0, '0, "R1 untrained trigger");

    // R2/R3: stream A gets chunk 0, indices 0..4
    for (int k = 0; k < 5; k++) train(PC_A, a_of(k));
    trig(a_of(0), 2'b11, a_of(1), a_of(2), "R3 chain A0");
    trig(a_of(3), 2'b01, a_of(4), '0,      "R7 partial A3");
    trig(a_of(4), 2'b00, '0, '0,           "R7 end of stream A4");

    // R4: B0 chunk1 (16), C0 chunk2 (32), B1..B15 -> 17..31, B16 -> chunk3 (48)
    train(PC_B, b_of(0));
    train(PC_C, C0);
    for (int k = 1; k < 18; k++) train(PC_B, b_of(k));
    for (int k = 0; k < 14; k++)
      trig(b_of(k), 2'b11, b_of(k+1), b_of(k+2), "R3 sweep B");
    trig(b_of(14), 2'b11, b_of(15), C0, "R7 walk across chunk");
    trig(b_of(15), 2'b01, C0, '0,       "R4 boundary did not chain");
    trig(b_of(16), 2'b01, b_of(17), '0, "R4 new chunk continues");
    trig(b_of(17), 2'b00, '0, '0,       "R4 tail");
    trig(32'h0000_9000, 2'b00, '0, '0,  "R8 forward miss");

    // R2/R10: PC_D aliases PC_A's index; D0 -> 64, D1 -> 65 (reverse idx 0,1)
    train(PC_D, D0);
    train(PC_D, D1);
    trig(a_of(0), 2'b10, '0, a_of(2), "R10 reverse tag mismatch");
    trig(D0, 2'b01, D1, '0,           "R2 aliased PC new chunk");
    train(PC_A, a_of(5));             // PC_A evicted: chunk5 -> 80
    trig(a_of(4), 2'b00, '0, '0,      "R2 evicted PC not chained");
    trig(D0, 2'b01, D1, '0,           "R2 alias left D stream intact");
    trig(a_of(5), 2'b00, '0, '0,      "R2 fresh chunk empty");

    // R5: E0 -> 96, F0 evicts E0 forward (-> 112), E1 -> 128
    train(PC_E, E0);
    train(PC_F, F0);
    train(PC_E, E1);
    trig(F0, 2'b00, '0, '0,           "R5 unmapped predecessor");
    train(PC_E, E2);
    trig(E1, 2'b01, E2, '0,           "R5 stream resumes");

    // R9: G0 -> 144; G1 trained in the same cycle as trigger G0
    train(PC_G, G0);
    @(negedge clk);
    trn_valid = 1'b1; trn_pc = PC_G; trn_addr = G1;
    trg_valid = 1'b1; trg_addr = G0;
    @(negedge clk);
    trn_valid = 1'b0; trg_valid = 1'b0;
    @(negedge clk);
    expect_pf(2'b01, G1, '0, "R9 train before trigger");

    // R10/R6: retrain A2 after A5 (80) -> 81
    train(PC_A, a_of(2));
    trig(a_of(5), 2'b01, a_of(2), '0, "R6 retrained A2 follows A5");
    trig(a_of(2), 2'b00, '0, '0,      "R10 old A2 mapping replaced");

    @(negedge clk);
    expect_pf(2'b00, '0, '0, "R1 idle after triggers");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule